// File: doc/BRIEF.md
# Asymmetric Address Generation Dispatcher

This block sits between a small ready queue of memory micro-operations and three address generation units. Each cycle it looks at up to `Q_DEPTH` queue entries, where entry 0 is the oldest. It decides which entries get a unit this cycle and raises a grant bit back to the queue for each entry it serves. An entry that gets no grant stays in the queue and is offered again in a later cycle.

Two of the units are general: each one takes a load or a store and computes base + (index << scale) + sign-extended displacement. The third unit is restricted. It takes only stores that carry no index register, so it only ever adds base and displacement. The dispatcher fills the restricted unit first. It then hands the oldest remaining entries to the two general units. Each unit registers its address and the entry's tag. Each unit also keeps a saturating count of the addresses it has produced, so its throughput can be observed.

Top module: `agu_dispatch`

## Requirements
- R1: A result address equals base + (index << scale) + displacement. The 2-bit scale gives a shift of 0 to 3. The 32-bit displacement is sign-extended to 64 bits. The index term is zero when the has-index bit is 0.
- R2: Unit 2 is the restricted unit. It receives the lowest-numbered valid entry whose store bit is 1 and whose has-index bit is 0. Entry 0 is the oldest.
- R3: A load (store bit 0) never goes to unit 2. No more than two loads are granted in one cycle.
- R4: Unit 0 receives the oldest valid entry not taken by unit 2, and unit 1 receives the next oldest one.
- R5: `out_grant` bit i is 1 in the same cycle exactly when entry i is assigned to some unit. At most three bits are set, and only bits of valid entries.
- R6: A unit's valid, address and tag appear on the clock edge after its grant. The tag is passed through unchanged. A unit with no grant shows valid 0 in the next cycle.
- R7: Reset (`rst_n` low, asynchronous) clears all result valids and all counters.
- R8: Each unit's counter adds one for each address the unit produces, and holds at all ones once it reaches that value.
- R9: A store with the has-index bit set is never given to unit 2. It is served by a general unit when it is among the two oldest remaining entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | Q_DEPTH | Entry holds an operation |
| in_store | input | Q_DEPTH | 1 = store, 0 = load |
| in_has_idx | input | Q_DEPTH | Entry uses an index register |
| in_base | input | Q_DEPTH x ADDR_W | Base register value |
| in_index | input | Q_DEPTH x ADDR_W | Index register value |
| in_scale | input | Q_DEPTH x 2 | Index shift amount |
| in_disp | input | Q_DEPTH x DISP_W | Signed displacement |
| in_tag | input | Q_DEPTH x TAG_W | Operation tag |
| out_grant | output | Q_DEPTH | Entry served this cycle |
| out_valid | output | 3 | Unit result valid |
| out_addr | output | 3 x ADDR_W | Unit result address |
| out_tag | output | 3 x TAG_W | Unit result tag |
| out_count | output | 3 x CNT_W | Addresses produced per unit |

## Verification
The assertions assume the queue drives known values on every entry field whenever reset is released. They also assume that the type and index bits of invalid entries do not matter. Several properties treat a grant in one cycle as the cause of a valid in the next cycle, so they need inputs that change only between edges. The bench drives all inputs on the falling edge and keeps invalid entries at zero. Every field it drives is a fixed function of the entry number and the step number, so each run repeats exactly.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int NUM_UNITS  = 3;
  localparam int STORE_UNIT = 2;
  localparam int SCALE_W    = 2;
endpackage

// File: rtl/agu_select.sv
module agu_select #(
  parameter int Q_DEPTH = 4,
  parameter int IDX_W   = $clog2(Q_DEPTH)
) (
  input  logic [Q_DEPTH-1:0]                      valid,
  input  logic [Q_DEPTH-1:0]                      is_store,
  input  logic [Q_DEPTH-1:0]                      has_idx,
  output logic [agu_pkg::NUM_UNITS-1:0]           pick_valid,
  output logic [agu_pkg::NUM_UNITS-1:0][IDX_W-1:0] pick_idx,
  output logic [Q_DEPTH-1:0]                      grant
);
  import agu_pkg::*;

  logic             st_found;
  logic [IDX_W-1:0] st_sel;
  logic [1:0]       n_full;
  logic [IDX_W-1:0] full0, full1;

  always_comb begin
    st_found = 1'b0;
    st_sel   = '0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      if (!st_found && valid[i] && is_store[i] && !has_idx[i]) begin
        st_found = 1'b1;
        st_sel   = IDX_W'(i);
      end
    end
    n_full = 2'd0;
    full0  = '0;
    full1  = '0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      if (valid[i] && !(st_found && st_sel == IDX_W'(i))) begin
        if (n_full == 2'd0) begin
          full0  = IDX_W'(i);
          n_full = 2'd1;
        end else if (n_full == 2'd1) begin
          full1  = IDX_W'(i);
          n_full = 2'd2;
        end
      end
    end
    pick_valid[0]          = (n_full != 2'd0);
    pick_valid[1]          = (n_full == 2'd2);
    pick_valid[STORE_UNIT] = st_found;
    pick_idx[0]            = full0;
    pick_idx[1]            = full1;
    pick_idx[STORE_UNIT]   = st_sel;
    for (int i = 0; i < Q_DEPTH; i++) begin
      grant[i] = 1'b0;
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (pick_valid[u] && pick_idx[u] == IDX_W'(i)) grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/agu_unit.sv
module agu_unit #(
  parameter bit SIMPLE = 1'b0,
  parameter int ADDR_W = 64,
  parameter int DISP_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic [ADDR_W-1:0]           base,
  input  logic [ADDR_W-1:0]           index,
  input  logic [agu_pkg::SCALE_W-1:0] scale,
  input  logic                        has_idx,
  input  logic [DISP_W-1:0]           disp,
  input  logic [TAG_W-1:0]            tag,
  output logic                        res_valid,
  output logic [ADDR_W-1:0]           res_addr,
  output logic [TAG_W-1:0]            res_tag
);
  logic [ADDR_W-1:0] idx_term;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] addr_nxt;

  generate
    if (SIMPLE) begin : g_simple
      assign idx_term = '0;
    end else begin : g_full
      assign idx_term = has_idx ? (index << scale) : '0;
    end
  endgenerate

  always_comb begin
    disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    addr_nxt = base + idx_term + disp_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_tag   <= '0;
    end else begin
      res_valid <= take;
      if (take) begin
        res_addr <= addr_nxt;
        res_tag  <= tag;
      end
    end
  end
endmodule

// File: rtl/agu_sat_counter.sv
module agu_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_nxt;
  logic             bump;

  always_comb begin
    bump      = inc && !(&count);
    count_nxt = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= count_nxt;
  end
endmodule

// File: rtl/agu_dispatch.sv
module agu_dispatch #(
  parameter int Q_DEPTH = 4,
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int TAG_W   = 4,
  parameter int CNT_W   = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [Q_DEPTH-1:0]                    in_valid,
  input  logic [Q_DEPTH-1:0]                    in_store,
  input  logic [Q_DEPTH-1:0]                    in_has_idx,
  input  logic [Q_DEPTH-1:0][ADDR_W-1:0]        in_base,
  input  logic [Q_DEPTH-1:0][ADDR_W-1:0]        in_index,
  input  logic [Q_DEPTH-1:0][1:0]               in_scale,
  input  logic [Q_DEPTH-1:0][DISP_W-1:0]        in_disp,
  input  logic [Q_DEPTH-1:0][TAG_W-1:0]         in_tag,
  output logic [Q_DEPTH-1:0]                    out_grant,
  output logic [2:0]                            out_valid,
  output logic [2:0][ADDR_W-1:0]                out_addr,
  output logic [2:0][TAG_W-1:0]                 out_tag,
  output logic [2:0][CNT_W-1:0]                 out_count
);
  import agu_pkg::*;

  localparam int IDX_W = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;

  logic [NUM_UNITS-1:0]            pick_valid;
  logic [NUM_UNITS-1:0][IDX_W-1:0] pick_idx;

  agu_select #(.Q_DEPTH(Q_DEPTH), .IDX_W(IDX_W)) u_select (
    .valid      (in_valid),
    .is_store   (in_store),
    .has_idx    (in_has_idx),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .grant      (out_grant)
  );

  generate
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
      agu_unit #(
        .SIMPLE (g == STORE_UNIT),
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .TAG_W  (TAG_W)
      ) u_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (pick_valid[g]),
        .base      (in_base[pick_idx[g]]),
        .index     (in_index[pick_idx[g]]),
        .scale     (in_scale[pick_idx[g]]),
        .has_idx   (in_has_idx[pick_idx[g]]),
        .disp      (in_disp[pick_idx[g]]),
        .tag       (in_tag[pick_idx[g]]),
        .res_valid (out_valid[g]),
        .res_addr  (out_addr[g]),
        .res_tag   (out_tag[g])
      );

      agu_sat_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pick_valid[g]),
        .count (out_count[g])
      );
    end
  endgenerate
endmodule

// File: rtl/agu_dispatch_chk.sv
module agu_dispatch_chk #(
  parameter int Q_DEPTH = 4,
  parameter int ADDR_W  = 64,
  parameter int TAG_W   = 4,
  parameter int CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [Q_DEPTH-1:0]       in_valid,
  input logic [Q_DEPTH-1:0]       in_store,
  input logic [Q_DEPTH-1:0]       in_has_idx,
  input logic [Q_DEPTH-1:0]       out_grant,
  input logic [2:0]               out_valid,
  input logic [2:0][CNT_W-1:0]    out_count
);
  assert_grant_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_grant & ~in_valid) == '0);

  assert_max_grants_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_grant) <= 3);

  assert_load_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_grant & ~in_store) <= 2);

  assert_store_unit_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_valid & in_store & ~in_has_idx)) |=> out_valid[2]);

  assert_two_served_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_valid) >= 2) |-> ($countones(out_grant) >= 2));

  assert_result_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(out_valid) == $past($countones(out_grant))));

  assert_reset_clear_R7: assert property (@(posedge clk)
    !rst_n |-> (out_valid == 3'b000));

  generate
    for (genvar u = 0; u < 3; u++) begin : g_cnt
      assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_count[u] == $past(out_count[u])) ||
        (out_count[u] == $past(out_count[u]) + CNT_W'(1)));
    end
  endgenerate
endmodule

bind agu_dispatch agu_dispatch_chk #(
  .Q_DEPTH (Q_DEPTH),
  .ADDR_W  (ADDR_W),
  .TAG_W   (TAG_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_store   (in_store),
  .in_has_idx (in_has_idx),
  .out_grant  (out_grant),
  .out_valid  (out_valid),
  .out_count  (out_count)
);

// File: tb/agu_dispatch_test.sv
module agu_dispatch_test;
  localparam int Q  = 4;
  localparam int CW = 4;
  localparam int NV = 10;
  localparam int CMAX = (1 << CW) - 1;

  // {valid[3:0], store[3:0], has_idx[3:0], src unit0, src unit1, src unit2}; src 7 = none
  localparam logic [20:0] VEC [NV] = '{
    {4'b1111, 4'b0000, 4'b0000, 3'd0, 3'd1, 3'd7},
    {4'b1111, 4'b1111, 4'b0000, 3'd1, 3'd2, 3'd0},
    {4'b1111, 4'b1000, 4'b0000, 3'd0, 3'd1, 3'd3},
    {4'b1111, 4'b1000, 4'b1000, 3'd0, 3'd1, 3'd7},
    {4'b1111, 4'b1010, 4'b0010, 3'd0, 3'd1, 3'd3},
    {4'b0101, 4'b0100, 4'b0000, 3'd0, 3'd7, 3'd2},
    {4'b0000, 4'b0000, 4'b0000, 3'd7, 3'd7, 3'd7},
    {4'b1010, 4'b0000, 4'b0000, 3'd1, 3'd3, 3'd7},
    {4'b0001, 4'b0001, 4'b0000, 3'd7, 3'd7, 3'd0},
    {4'b1111, 4'b0110, 4'b0100, 3'd0, 3'd2, 3'd1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [Q-1:0] in_valid, in_store, in_has_idx;
  logic [Q-1:0][63:0] in_base, in_index;
  logic [Q-1:0][1:0] in_scale;
  logic [Q-1:0][31:0] in_disp;
  logic [Q-1:0][3:0] in_tag;
  logic [Q-1:0] out_grant;
  logic [2:0] out_valid;
  logic [2:0][63:0] out_addr;
  logic [2:0][3:0] out_tag;
  logic [2:0][CW-1:0] out_count;

  int n_chk = 0;
  int n_fail = 0;
  int cnt_exp [3] = '{0, 0, 0};
  bit done = 1'b0;

  always #4 clk = ~clk;

  agu_dispatch #(.Q_DEPTH(Q), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_store(in_store),
    .in_has_idx(in_has_idx), .in_base(in_base), .in_index(in_index),
    .in_scale(in_scale), .in_disp(in_disp), .in_tag(in_tag),
    .out_grant(out_grant), .out_valid(out_valid), .out_addr(out_addr),
    .out_tag(out_tag), .out_count(out_count)
  );

  function automatic logic [63:0] f_base(int e, int k);
    return (64'(k + 1) << 40) | (64'(e) << 8);
  endfunction
  function automatic logic [63:0] f_index(int e, int k);
    return 64'(e + 3 + k);
  endfunction
  function automatic logic [1:0] f_scale(int e, int k);
    return 2'((e + k) % 4);
  endfunction
  function automatic logic [31:0] f_disp(int e, int k);
    return (e % 2 == 1) ? 32'(-16 * (k + 1)) : 32'(8 * e + k);
  endfunction
  function automatic logic [63:0] f_addr(int e, int k, bit hx);
    logic [31:0] d;
    d = f_disp(e, k);
    return f_base(e, k) + (hx ? (f_index(e, k) << f_scale(e, k)) : 64'd0)
           + {{32{d[31]}}, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input int k);
    for (int e = 0; e < Q; e++) begin
      in_valid[e]   = VEC[k][17 + e];
      in_store[e]   = VEC[k][13 + e] & VEC[k][17 + e];
      in_has_idx[e] = VEC[k][9 + e] & VEC[k][17 + e];
      in_base[e]    = f_base(e, k);
      in_index[e]   = f_index(e, k);
      in_scale[e]   = f_scale(e, k);
      in_disp[e]    = f_disp(e, k);
      in_tag[e]     = 4'((k * 4 + e) % 16);
    end
  endtask

  function automatic int src_of(int k, int u);
    return int'(VEC[k][8 - 3 * u -: 3]);
  endfunction

  // one vector: drive, check grants, step a clock, check unit results and counts
  task automatic run_vec(input int k);
    logic [Q-1:0] g_exp;
    drive(k);
    g_exp = '0;
    for (int u = 0; u < 3; u++) if (src_of(k, u) != 7) g_exp[src_of(k, u)] = 1'b1;
    #1;
    chk(out_grant == g_exp, "R2/R3/R4/R5/R9 grant", 64'(out_grant), 64'(g_exp));
    @(negedge clk);
    for (int u = 0; u < 3; u++) begin
      int s;
      s = src_of(k, u);
      chk(out_valid[u] == (s != 7), "R6 valid", 64'(out_valid[u]), 64'(s != 7));
      if (s != 7) begin
        cnt_exp[u]++;
        chk(out_addr[u] == f_addr(s, k, VEC[k][9 + s]), "R1 address",
            out_addr[u], f_addr(s, k, VEC[k][9 + s]));
        chk(out_tag[u] == 4'((k * 4 + s) % 16), "R6 tag",
            64'(out_tag[u]), 64'((k * 4 + s) % 16));
      end
      chk(int'(out_count[u]) == ((cnt_exp[u] > CMAX) ? CMAX : cnt_exp[u]), "R8 count",
          64'(out_count[u]), 64'((cnt_exp[u] > CMAX) ? CMAX : cnt_exp[u]));
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = '0; in_store = '0; in_has_idx = '0;
    in_base = '0; in_index = '0; in_scale = '0; in_disp = '0; in_tag = '0;
    repeat (2) @(negedge clk);
    // R7: reset state
    chk(out_valid == 3'b000, "R7 valid after reset", 64'(out_valid), 64'd0);
    for (int u = 0; u < 3; u++)
      chk(out_count[u] == '0, "R7 count after reset", 64'(out_count[u]), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table
    for (int k = 0; k < NV; k++) run_vec(k);

    // R8: saturation with a full queue of index-free stores
    for (int r = 0; r < 12; r++) run_vec(1);
    for (int u = 0; u < 3; u++)
      chk(int'(out_count[u]) == CMAX, "R8 saturated", 64'(out_count[u]), 64'(CMAX));

    // R7: reset during traffic clears results and counters at once
    rst_n = 1'b0;
    #1;
    chk(out_valid == 3'b000, "R7 valid mid-run reset", 64'(out_valid), 64'd0);
    for (int u = 0; u < 3; u++)
      chk(out_count[u] == '0, "R7 count mid-run reset", 64'(out_count[u]), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int u = 0; u < 3; u++) cnt_exp[u] = 0;
    // R3: after reset, loads only -> unit 2 stays idle
    run_vec(0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule